// File: doc/BRIEF.md
# Dual-Mode PWM Timebase Channel

This block is one PWM timebase channel. A clock tick generator (an 8-bit prescaler followed by a power-of-two divider) advances a counter. The counter runs in one of two modes. In edge mode it ramps up and then wraps. In center mode it counts up to one past the period value and then back down. The output is high while the counter is below the active compare value. Period, compare and the mode bit are double-buffered, so a write lands in a buffer and moves into the active set only at the next period boundary.

Each counting tick can raise three sticky flags and a one-cycle converter-start pulse. The flags are for period, duty and trigger events. Software picks which counter event raises each one through a small write-only register port. It clears a flag by writing a 1 to its bit. A zero period stops the counter until a non-zero period is written.

Top module: `pwm_timebase`

## Requirements
- R1: After a synchronous active-low reset, every setting and buffer is zero: edge mode, prescaler 0, divider code 0, period 0 and compare 0. The counter is held at 0, `pwm_out` is low, and all flags and `adc_trig` are 0.
- R2: Ticks occur once every (P+1)·D clocks while `en` is high, where P is the prescaler value at address 1 [7:0]. D comes from the divider code at address 2 [2:0]: code 4 gives 1, code 0 gives 2, code 1 gives 4, code 2 gives 8 and code 3 gives 16. Codes 5 to 7 also give 1.
- R3: In edge mode (address 0 bit 0 = 0) the counter steps 0,1,…,N and wraps to 0 on the tick at N. A period therefore lasts N+1 ticks.
- R4: In center mode (address 0 bit 0 = 1) the counter steps up 0…N+1 and then down N…1. The tick at 1 while counting down returns it to 0, so a period lasts 2N+2 ticks.
- R5: `pwm_out` is high exactly while the counter is below the active compare value C. C = 0 gives a constant low. C above the highest count (N in edge mode, N+1 in center mode) gives a constant high.
- R6: Writes to period (address 3), compare (address 4) and the mode bit take effect only at a period boundary. A write in the middle of a period leaves the current period unchanged.
- R7: While the active period is 0, the counter stays at 0, `pwm_out` is low and no event fires. On every tick the buffered values are copied into the active set, so writing a non-zero period restarts the counter.
- R8: Address 0 bit 1 selects the period flag source. A value of 0 selects the boundary: the wrap in edge mode, or the down-count reaching 0 in center mode. A value of 1 selects the counter equal to N while counting up.
- R9: Address 0 bit 2 selects the duty flag source. A value of 1 selects a compare match while counting up; edge mode always counts up. A value of 0 selects a compare match while counting down, which never happens in edge mode.
- R10: Address 0 bits [4:3] select the source of `adc_trig`, a one-clock pulse. Code 0 is an output rising edge, 1 an output falling edge, 2 the center peak (N+1 in center mode) and 3 the boundary. Each pulse also sets `adc_flag`.
- R11: The flags are sticky. Writing 1 to a bit at address 5 clears it: bit 0 is period, bit 1 is duty and bit 2 is trigger. If a flag is set and cleared in the same cycle, the set wins.
- R12: While `en` is low, the prescaler, divider and counter hold their state and no event fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable for the tick chain and counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 1 | PWM waveform |
| prd_flag | output | 1 | Sticky period flag |
| duty_flag | output | 1 | Sticky duty flag |
| adc_flag | output | 1 | Sticky converter-trigger flag |
| adc_trig | output | 1 | One-clock converter-start pulse |

## Verification
Two things can happen in one cycle: a counter event that sets a sticky flag, and a software write that clears the same flag. To provoke this, the channel runs in edge mode with a period of 1 and one tick per clock, so a boundary occurs on every second clock. The clear bit is then held asserted for six clocks. The flag must read high after every event edge and low after every other edge, three of six samples, because the set takes priority. A behavioural model, compared on every clock, judges the same collision together with period-boundary loads that coincide with buffer writes.

// File: rtl/pwm_timebase_pkg.sv
// Package: shared constants, register layout and divider decode for the
// PWM timebase channel. Assumes a 3-bit register address space.
package pwm_timebase_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] A_PRESC   = 3'd1;
    localparam logic [ADDR_W-1:0] A_DIVSEL  = 3'd2;
    localparam logic [ADDR_W-1:0] A_PERIOD  = 3'd3;
    localparam logic [ADDR_W-1:0] A_COMPARE = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLAGCLR = 3'd5;

    localparam int FLG_PRD  = 0;
    localparam int FLG_DUTY = 1;
    localparam int FLG_ADC  = 2;
    localparam int FLG_N    = 3;

    typedef enum logic [1:0] {
        TRG_RISE = 2'd0,
        TRG_FALL = 2'd1,
        TRG_PEAK = 2'd2,
        TRG_END  = 2'd3
    } trig_sel_e;

    // Control word; bit 0 (center) is buffered, the rest act at once.
    typedef struct packed {
        trig_sel_e trig_sel;     // [4:3]
        logic      duty_on_up;   // [2]
        logic      prd_on_match; // [1]
        logic      center;       // [0]
    } ctrl_t;

    // Divider code to shift amount: 4->0, 0->1, 1->2, 2->3, 3->4, rest->0.
    function automatic logic [2:0] div_shift(input logic [2:0] code);
        case (code)
            3'd0:    return 3'd1;
            3'd1:    return 3'd2;
            3'd2:    return 3'd3;
            3'd3:    return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/pwm_tickgen.sv
// Tick generator: a prescaler dividing by (presc+1) feeds a free-running
// divider counter whose low bits select a power-of-two ratio. Assumes
// DIV_W is wide enough for the largest shift (4).
module pwm_tickgen
    import pwm_timebase_pkg::*;
#(
    parameter int PS_W  = 8,
    parameter int DIV_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [PS_W-1:0] presc,
    input  logic [2:0]      div_code,
    output logic            tick
);

    logic [PS_W-1:0]  pcnt;
    logic [DIV_W-1:0] dcnt;
    logic [DIV_W-1:0] dmask;
    logic             pre_tick;

    // Prescaler terminal count and divider ratio mask.
    always_comb begin
        pre_tick = en && (pcnt >= presc);
        dmask    = DIV_W'((32'd1 << div_shift(div_code)) - 32'd1);
        tick     = pre_tick && ((dcnt & dmask) == dmask);
    end

    // Prescaler counter, frozen while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pcnt <= '0;
        else if (en)
            pcnt <= pre_tick ? '0 : pcnt + 1'b1;
    end

    // Divider counter, advances once per prescaler terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dcnt <= '0;
        else if (pre_tick)
            dcnt <= dcnt + 1'b1;
    end

endmodule

// File: rtl/pwm_cfg.sv
// Configuration registers: control word, prescaler, divider code and the
// period/compare buffers written through a simple strobe port. Also
// decodes the write-one-to-clear strobe for the flags. Assumes
// DATA_W >= 8.
module pwm_cfg
    import pwm_timebase_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PS_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic [PS_W-1:0]   presc,
    output logic [2:0]        div_code,
    output logic [DATA_W-1:0] prd_buf,
    output logic [DATA_W-1:0] cmp_buf,
    output logic [FLG_N-1:0]  flag_clr
);

    localparam int CTRL_W = $bits(ctrl_t);

    // Register writes; every field resets to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl     <= '0;
            presc    <= '0;
            div_code <= '0;
            prd_buf  <= '0;
            cmp_buf  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL:    ctrl     <= ctrl_t'(wr_data[CTRL_W-1:0]);
                A_PRESC:   presc    <= wr_data[PS_W-1:0];
                A_DIVSEL:  div_code <= wr_data[2:0];
                A_PERIOD:  prd_buf  <= wr_data;
                A_COMPARE: cmp_buf  <= wr_data;
                default: ;
            endcase
        end
    end

    // Clear strobe for the sticky flags.
    always_comb begin
        flag_clr = (wr_en && (wr_addr == A_FLAGCLR)) ? wr_data[FLG_N-1:0] : '0;
    end

endmodule

// File: rtl/pwm_count.sv
// Counter core: edge or center counting, active period/compare/mode
// loaded from the buffers at each boundary (or on every tick while the
// active period is zero), PWM output and per-tick event strobes.
// Assumes tick is a single-cycle enable.
module pwm_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] prd_buf,
    input  logic [CNT_W-1:0] cmp_buf,
    input  logic             center_buf,
    output logic [CNT_W:0]   cnt,
    output logic             cnt_down,
    output logic [CNT_W-1:0] prd_act,
    output logic [CNT_W-1:0] cmp_act,
    output logic             center_act,
    output logic             running,
    output logic             pwm,
    output logic             ev_end,
    output logic             ev_match,
    output logic             ev_dup,
    output logic             ev_ddn,
    output logic             ev_peak,
    output logic             ev_rise,
    output logic             ev_fall
);

    localparam int CW = CNT_W + 1;

    logic [CW-1:0]    prd_ext, cmp_ext, peak;
    logic [CW-1:0]    cnt_n;
    logic             down_n, load;
    logic [CNT_W-1:0] prd_n, cmp_n;
    logic             center_n, pwm_n;

    // Next counter state and boundary detection.
    always_comb begin
        prd_ext = {1'b0, prd_act};
        cmp_ext = {1'b0, cmp_act};
        peak    = prd_ext + 1'b1;
        running = (prd_act != '0);
        cnt_n   = cnt;
        down_n  = cnt_down;
        load    = 1'b0;
        if (!running) begin
            cnt_n  = '0;
            down_n = 1'b0;
            load   = 1'b1;
        end else if (!center_act) begin
            if (cnt == prd_ext) begin
                cnt_n = '0;
                load  = 1'b1;
            end else begin
                cnt_n = cnt + 1'b1;
            end
        end else if (!cnt_down) begin
            if (cnt == peak) begin
                cnt_n  = prd_ext;
                down_n = 1'b1;
            end else begin
                cnt_n = cnt + 1'b1;
            end
        end else begin
            if (cnt == CW'(1)) begin
                cnt_n  = '0;
                down_n = 1'b0;
                load   = 1'b1;
            end else begin
                cnt_n = cnt - 1'b1;
            end
        end
        prd_n    = load ? prd_buf    : prd_act;
        cmp_n    = load ? cmp_buf    : cmp_act;
        center_n = load ? center_buf : center_act;
    end

    // Output level now and after the coming tick.
    always_comb begin
        pwm   = running && (cnt < cmp_ext);
        pwm_n = (prd_n != '0) && (cnt_n < {1'b0, cmp_n});
    end

    // Event strobes, valid only on a tick.
    always_comb begin
        ev_end   = tick && running &&
                   (center_act ? (cnt_down && cnt == CW'(1)) : (cnt == prd_ext));
        ev_match = tick && running && !cnt_down && (cnt == prd_ext);
        ev_dup   = tick && running && !cnt_down && (cnt == cmp_ext);
        ev_ddn   = tick && running && cnt_down && (cnt == cmp_ext);
        ev_peak  = tick && running && center_act && !cnt_down && (cnt == peak);
        ev_rise  = tick && !pwm && pwm_n;
        ev_fall  = tick && pwm && !pwm_n;
    end

    // Counter and active register update on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            cnt_down   <= 1'b0;
            prd_act    <= '0;
            cmp_act    <= '0;
            center_act <= 1'b0;
        end else if (tick) begin
            cnt        <= cnt_n;
            cnt_down   <= down_n;
            prd_act    <= prd_n;
            cmp_act    <= cmp_n;
            center_act <= center_n;
        end
    end

endmodule

// File: rtl/pwm_timebase.sv
// Top of the PWM timebase channel: ties configuration, tick generation
// and counter together, selects the event behind each flag and the
// converter trigger, and keeps the sticky flags (set wins over clear).
module pwm_timebase
    import pwm_timebase_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PS_W  = 8,
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out,
    output logic             prd_flag,
    output logic             duty_flag,
    output logic             adc_flag,
    output logic             adc_trig
);

    ctrl_t            ctrl;
    logic [PS_W-1:0]  presc;
    logic [2:0]       div_code;
    logic [CNT_W-1:0] prd_buf, cmp_buf;
    logic [FLG_N-1:0] flag_clr;
    logic             tick;
    logic [CNT_W:0]   cnt;
    logic             cnt_down;
    logic [CNT_W-1:0] prd_act, cmp_act;
    logic             center_act, running, pwm;
    logic             ev_end, ev_match, ev_dup, ev_ddn, ev_peak, ev_rise, ev_fall;
    logic [FLG_N-1:0] flag_set, flags_q;
    logic             trig_hit, trig_q;

    pwm_cfg #(.DATA_W(CNT_W), .PS_W(PS_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ctrl     (ctrl),
        .presc    (presc),
        .div_code (div_code),
        .prd_buf  (prd_buf),
        .cmp_buf  (cmp_buf),
        .flag_clr (flag_clr)
    );

    pwm_tickgen #(.PS_W(PS_W), .DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .presc    (presc),
        .div_code (div_code),
        .tick     (tick)
    );

    pwm_count #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .prd_buf    (prd_buf),
        .cmp_buf    (cmp_buf),
        .center_buf (ctrl.center),
        .cnt        (cnt),
        .cnt_down   (cnt_down),
        .prd_act    (prd_act),
        .cmp_act    (cmp_act),
        .center_act (center_act),
        .running    (running),
        .pwm        (pwm),
        .ev_end     (ev_end),
        .ev_match   (ev_match),
        .ev_dup     (ev_dup),
        .ev_ddn     (ev_ddn),
        .ev_peak    (ev_peak),
        .ev_rise    (ev_rise),
        .ev_fall    (ev_fall)
    );

    // Pick the event behind each flag and behind the trigger.
    always_comb begin
        case (ctrl.trig_sel)
            TRG_RISE: trig_hit = ev_rise;
            TRG_FALL: trig_hit = ev_fall;
            TRG_PEAK: trig_hit = ev_peak;
            default:  trig_hit = ev_end;
        endcase
        flag_set           = '0;
        flag_set[FLG_PRD]  = ctrl.prd_on_match ? ev_match : ev_end;
        flag_set[FLG_DUTY] = ctrl.duty_on_up ? ev_dup : ev_ddn;
        flag_set[FLG_ADC]  = trig_hit;
    end

    // Sticky flags and the one-cycle trigger pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            trig_q  <= 1'b0;
        end else begin
            flags_q <= (flags_q & ~flag_clr) | flag_set;
            trig_q  <= trig_hit;
        end
    end

    assign pwm_out   = pwm;
    assign prd_flag  = flags_q[FLG_PRD];
    assign duty_flag = flags_q[FLG_DUTY];
    assign adc_flag  = flags_q[FLG_ADC];
    assign adc_trig  = trig_q;

endmodule

// File: rtl/pwm_timebase_chk.sv
// Checker for the PWM timebase: temporal properties on ports and on the
// signals passed between the counter, tick generator and flag logic.
module pwm_timebase_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic             clr_prd_bit,
    input logic             tick,
    input logic [CNT_W:0]   cnt,
    input logic [CNT_W-1:0] prd_act,
    input logic [CNT_W-1:0] cmp_act,
    input logic             center_act,
    input logic             running,
    input logic             pwm_out,
    input logic             prd_flag,
    input logic             adc_trig
);

    // R3: edge counting never passes the period.
    assert_edge_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !center_act) |-> (cnt <= {1'b0, prd_act}));

    // R4: center counting never passes the peak.
    assert_center_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && center_act) |-> (cnt <= ({1'b0, prd_act} + 1'b1)));

    // R5: zero compare keeps the output low.
    assert_zero_cmp_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_act == '0) |-> !pwm_out);

    // R6: active values change only on a tick.
    assert_buffer_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(prd_act) && $stable(cmp_act) && $stable(center_act)));

    // R7: a stopped counter drives low.
    assert_stop_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prd_act == '0) |-> !pwm_out);

    // R10: a trigger pulse follows a tick.
    assert_trig_after_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |-> $past(tick));

    // R11: a set period flag stays set unless cleared.
    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (prd_flag && !(wr_en && wr_addr == 3'd5 && clr_prd_bit)) |=> prd_flag);

    // R12: disabled channel holds its counter.
    assert_freeze_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt));

endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .clr_prd_bit (wr_data[0]),
    .tick        (tick),
    .cnt         (cnt),
    .prd_act     (prd_act),
    .cmp_act     (cmp_act),
    .center_act  (center_act),
    .running     (running),
    .pwm_out     (pwm_out),
    .prd_flag    (prd_flag),
    .adc_trig    (adc_trig)
);

// File: tb/sim_pwm_timebase.sv
// Bench for pwm_timebase: behavioural model compared every clock, plus
// directed interval and duty measurements.
module sim_pwm_timebase;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_out, prd_flag, duty_flag, adc_flag, adc_trig;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    bit model_on = 0;

    pwm_timebase u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .prd_flag(prd_flag),
        .duty_flag(duty_flag), .adc_flag(adc_flag), .adc_trig(adc_trig)
    );

    always #4 clk = ~clk;

    // Reference model state.
    int m_pcnt, m_dcnt, m_cnt, m_prd, m_cmp, b_prd, b_cmp, s_ps, s_div, s_trig;
    bit m_down, m_center, b_center, s_pm, s_du, f_prd, f_duty, f_adc, m_trig;

    function automatic int dfac(input int c);
        case (c)
            0: return 2;
            1: return 4;
            2: return 8;
            3: return 16;
            default: return 1;
        endcase
    endfunction

    function automatic bit mout(input int c, input int p, input int k);
        return (p != 0) && (c < k);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin : model
        int nc, np, ncm, clr;
        bit pre, tk, nd, ld, ncen;
        bit e_end, e_match, e_dup, e_ddn, e_peak, e_rise, e_fall, st;
        if (!rst_n) begin
            m_pcnt = 0; m_dcnt = 0; m_cnt = 0; m_prd = 0; m_cmp = 0;
            b_prd = 0; b_cmp = 0; s_ps = 0; s_div = 0; s_trig = 0;
            m_down = 0; m_center = 0; b_center = 0; s_pm = 0; s_du = 0;
            f_prd = 0; f_duty = 0; f_adc = 0; m_trig = 0;
        end else begin
            e_end = 0; e_match = 0; e_dup = 0; e_ddn = 0; e_peak = 0;
            e_rise = 0; e_fall = 0;
            pre = en && (m_pcnt >= s_ps);
            tk = pre && ((m_dcnt % dfac(s_div)) == dfac(s_div) - 1);
            if (en) m_pcnt = pre ? 0 : m_pcnt + 1;
            if (pre) m_dcnt = (m_dcnt + 1) % 16;
            if (tk) begin
                nc = m_cnt; nd = m_down; ld = 0;
                if (m_prd == 0) begin
                    nc = 0; nd = 0; ld = 1;
                end else if (!m_center) begin
                    e_end = (m_cnt == m_prd); e_match = e_end; e_dup = (m_cnt == m_cmp);
                    if (e_end) begin nc = 0; ld = 1; end else nc = m_cnt + 1;
                end else if (!m_down) begin
                    e_match = (m_cnt == m_prd); e_dup = (m_cnt == m_cmp);
                    e_peak = (m_cnt == m_prd + 1);
                    if (e_peak) begin nc = m_prd; nd = 1; end else nc = m_cnt + 1;
                end else begin
                    e_ddn = (m_cnt == m_cmp); e_end = (m_cnt == 1);
                    if (e_end) begin nc = 0; nd = 0; ld = 1; end else nc = m_cnt - 1;
                end
                np = ld ? b_prd : m_prd;
                ncm = ld ? b_cmp : m_cmp;
                ncen = ld ? b_center : m_center;
                e_rise = !mout(m_cnt, m_prd, m_cmp) && mout(nc, np, ncm);
                e_fall = mout(m_cnt, m_prd, m_cmp) && !mout(nc, np, ncm);
                m_cnt = nc; m_down = nd; m_prd = np; m_cmp = ncm; m_center = ncen;
            end
            case (s_trig)
                0: st = e_rise;
                1: st = e_fall;
                2: st = e_peak;
                default: st = e_end;
            endcase
            clr = (wr_en && wr_addr == 3'd5) ? int'(wr_data[2:0]) : 0;
            f_prd  = (f_prd && !clr[0]) || (s_pm ? e_match : e_end);
            f_duty = (f_duty && !clr[1]) || (s_du ? e_dup : e_ddn);
            f_adc  = (f_adc && !clr[2]) || st;
            m_trig = st;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin
                        s_trig = int'(wr_data[4:3]); s_du = wr_data[2];
                        s_pm = wr_data[1]; b_center = wr_data[0];
                    end
                    3'd1: s_ps = int'(wr_data[7:0]);
                    3'd2: s_div = int'(wr_data[2:0]);
                    3'd3: b_prd = int'(wr_data);
                    3'd4: b_cmp = int'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (model_on && !done) begin
            chk("R5 pwm_out model", int'(pwm_out), int'(mout(m_cnt, m_prd, m_cmp)));
            chk("R8 prd_flag model", int'(prd_flag), int'(f_prd));
            chk("R9 duty_flag model", int'(duty_flag), int'(f_duty));
            chk("R11 adc_flag model", int'(adc_flag), int'(f_adc));
            chk("R10 adc_trig model", int'(adc_trig), int'(m_trig));
        end
    end

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_trig();
        do @(negedge clk); while (!adc_trig);
    endtask

    task automatic interval(output int n);
        wait_trig();
        n = 0;
        do begin n++; @(negedge clk); end while (!adc_trig);
    endtask

    task automatic high_count(input bit do_wr, input int a, input int d, output int n);
        wait_trig();
        n = 0;
        for (int i = 0; i < 100000; i++) begin
            if (pwm_out) n++;
            if (do_wr && i == 3) begin wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d); end
            if (do_wr && i == 4) wr_en = 1'b0;
            @(negedge clk);
            if (adc_trig) break;
        end
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not complete actual=0 expected=1");
        finish_run();
    end

    initial begin : main
        int n, hi;
        en = 1'b1;
        repeat (5) @(negedge clk);
        // R1: reset state visible at the ports
        chk("R1 pwm_out in reset", int'(pwm_out), 0);
        chk("R1 flags in reset", int'({prd_flag, duty_flag, adc_flag, adc_trig}), 0);
        rst_n = 1'b1;
        model_on = 1;
        repeat (20) @(negedge clk);
        chk("R1 R7 idle after reset, output low", int'(pwm_out), 0);
        chk("R1 no flags after reset", int'({prd_flag, duty_flag, adc_flag}), 0);

        // Edge mode, prescaler 1, divide by 1, period 9, compare 4
        wr(1, 1); wr(2, 4); wr(0, 'h18); wr(4, 4); wr(3, 9);
        wait_trig();
        interval(n);
        chk("R3 R2 edge period clocks", n, 20);
        high_count(0, 0, 0, hi);
        chk("R5 edge high clocks", hi, 8);
        high_count(1, 4, 7, hi);
        chk("R6 mid-period compare write ignored", hi, 8);
        high_count(0, 0, 0, hi);
        chk("R6 compare applied next period", hi, 14);

        // Divider codes with prescaler 0, period 9
        wr(1, 0);
        wr(2, 3); wait_trig(); interval(n);
        chk("R2 divider code 3 -> 16", n, 160);
        wr(2, 0); wait_trig(); interval(n);
        chk("R2 divider code 0 -> 2", n, 20);
        wr(2, 2); wait_trig(); interval(n);
        chk("R2 divider code 2 -> 8", n, 80);
        wr(2, 6); wait_trig(); interval(n);
        chk("R2 divider code 6 -> 1", n, 10);

        // Center mode, period 4, compare 2
        wr(0, 'h19); wr(3, 4); wr(4, 2);
        wait_trig(); wait_trig();
        interval(n);
        chk("R4 center period clocks", n, 10);
        high_count(0, 0, 0, hi);
        chk("R5 center high clocks", hi, 3);
        wr(4, 0); wait_trig(); high_count(0, 0, 0, hi);
        chk("R5 compare 0 constant low", hi, 0);
        wr(4, 5); wait_trig(); high_count(0, 0, 0, hi);
        chk("R5 compare at peak", hi, 9);
        wr(4, 6); wait_trig(); high_count(0, 0, 0, hi);
        chk("R5 compare above peak constant high", hi, 10);

        // Trigger sources
        wr(4, 2);
        wr(0, 'h11); wait_trig(); interval(n);
        chk("R10 peak trigger interval", n, 10);
        wr(0, 'h01); wait_trig(); wait_trig();
        chk("R10 rising trigger sees output high", int'(pwm_out), 1);
        wr(0, 'h09); wait_trig(); wait_trig();
        chk("R10 falling trigger sees output low", int'(pwm_out), 0);

        // Flags: clear right after a boundary, then let one period run
        wr(0, 'h1D); wait_trig(); wait_trig();
        wr(5, 7);
        chk("R11 flags cleared by write-one", int'({prd_flag, duty_flag, adc_flag}), 0);
        repeat (12) @(negedge clk);
        chk("R8 period flag set", int'(prd_flag), 1);
        chk("R9 duty flag set on up match", int'(duty_flag), 1);
        chk("R11 trigger flag sticky", int'(adc_flag), 1);
        // Period flag on period match (center, counting up)
        wr(0, 'h1F); wait_trig(); wr(5, 1);
        repeat (12) @(negedge clk);
        chk("R8 period flag on match", int'(prd_flag), 1);

        // Edge mode: duty on down-count never fires
        wr(0, 'h18); wait_trig(); wait_trig(); wait_trig();
        wr(5, 7);
        repeat (30) @(negedge clk);
        chk("R9 down-match never fires in edge mode", int'(duty_flag), 0);

        // Collision: boundary every 2 clocks, clear held for 6 clocks
        wr(3, 1); wait_trig(); wait_trig(); wait_trig();
        wr_en = 1'b1; wr_addr = 3'd5; wr_data = 16'd1;
        hi = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (prd_flag) hi++;
        end
        wr_en = 1'b0;
        chk("R11 set wins over clear", hi, 3);

        // Zero period stops the counter
        wr(3, 0);
        repeat (10) @(negedge clk);
        hi = 0; n = 0;
        for (int i = 0; i < 100; i++) begin
            if (pwm_out) hi++;
            if (adc_trig) n++;
            @(negedge clk);
        end
        chk("R7 stopped output low", hi, 0);
        chk("R7 stopped no trigger", n, 0);
        wr(3, 3);
        wait_trig(); interval(n);
        chk("R7 restart after non-zero period", n, 4);

        // Enable low freezes the channel
        wr(4, 2); wait_trig(); @(negedge clk);
        en = 1'b0;
        hi = int'(pwm_out); n = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (int'(pwm_out) != hi || adc_trig) n++;
        end
        chk("R12 frozen while disabled", n, 0);
        en = 1'b1;
        wait_trig(); interval(n);
        chk("R12 resumes after enable", n, 4);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule